// File: doc/BRIEF.md
# PWM Generator with Chopper and Trip

This block produces two pulse-width-modulated outputs, A and B, from one 16-bit time-base counter. The counter runs as a sawtooth up, a sawtooth down, or a triangle up then down, and its top value comes from a period register. Two compare values and the period/zero points form a set of counter events. Each output has its own action word, which says what that output does on each event: nothing, clear, set or toggle. With these settings the outputs give single-edge, symmetric dual-edge or asymmetric dual-edge waveforms.

After the action stage, an optional chopper ANDs both outputs with a square carrier taken from the system clock. A trip input then has the last word. While it is asserted, each output is driven at once, with no clock in between, to a programmed safe level. The trip is also held in a latch that releases in one of two ways, depending on the mode chosen: automatically at the next counter zero, or only when software clears it.

Software sets the block up through a simple write-only register port. The period and compare writes go to shadow copies, and these move into the active copies only when the counter is at zero. A change of duty therefore never cuts a PWM cycle short.

Top module: `pwm_chop_trip`

## Requirements
- R1: After reset the counter is 0, every register is 0, both outputs are low, and no write is pending. A register is written when `wr_en` is high at a rising clock edge; the register is picked by `wr_addr` and the value is `wr_data`.
- R2: Up mode: address 3 bits [1:0] = 0. The counter runs 0,1,…,P and then back to 0, so each PWM cycle is P+1 clocks, where P is the period written at address 0. An output whose action is set at zero and clear on an up-count compare match is high for C clocks of each cycle, where C is its compare value.
- R3: Output A uses compare A, written at address 1. Output B uses compare B, written at address 2. Each output has its own action word, so the two outputs can carry different duties at the same time.
- R4: Up-down mode: mode code 2. The counter runs 0→P→0, so each cycle is 2·P clocks. If an output sets on compare A while counting up and clears on compare A while counting down, its pulse is centred on P and lasts 2·(P−C) clocks.
- R5: Asymmetric dual-edge: in up-down mode, one output may set on the compare A up-count match and clear on the compare B down-count match. Its two edges are then placed independently.
- R6: Down mode: mode code 1. The counter runs P,P−1,…,0 and then reloads P. An output that sets at the period point and clears on a down-count compare match is high for P−C clocks of each cycle.
- R7: Action words are at address 4 (output A) and address 5 (output B). They have six 2-bit fields: [1:0] zero, [3:2] period, [5:4] compare A up, [7:6] compare A down, [9:8] compare B up, [11:10] compare B down. Each field holds 0 = no change, 1 = clear, 2 = set, 3 = toggle. The output register changes on the clock edge that ends the counter state where the event occurs.
- R8: If several events occur in the same counter state, the one highest in this list wins: compare B down, compare B up, compare A down, compare A up, period, zero. Events whose field is 0 take no part.
- R9: A write to the period or to a compare value takes effect only from the clock edge that ends a counter state equal to 0. Until then the current cycle keeps the old value.
- R10: Chopper, address 6: bit 0 enables it, and bits [8:1] hold a divider value D. When enabled, both outputs are ANDed with a carrier that toggles every D+1 clocks. When disabled, the outputs pass through unchanged.
- R11: Trip force, address 7: field [2:1] sets the level for A and field [4:3] sets it for B, with codes 1 = low, 2 = high, and 0 or 3 = no override. While `trip_in` is high, the forced level appears on the outputs in the same cycle, with no clock edge in between.
- R12: Cycle-by-cycle mode: address 7 bit 0 = 0. Once `trip_in` has been high, the force stays in effect until the first clock edge that ends a counter-zero state with `trip_in` low.
- R13: One-shot mode: address 7 bit 0 = 1. Once `trip_in` has been high, the force stays in effect, through any number of counter zeros, until a write to address 7 with bit 5 set. Bit 5 is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the chopper carrier source |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write value |
| trip_in | input | 1 | Trip request, active high, acts without a clock |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
An event in a counter state shows on an output one clock later. A register write shows up only after the next counter zero. For this reason the duty checks first wait a settling interval longer than two of the slowest cycles that came before, and then count high clocks over a window that is a whole number of PWM cycles; that count does not depend on phase. A trip acts within the same cycle, so its checks sample the outputs 1 ns after the negative edge that raised `trip_in`. The hold and release checks first lock onto the rising edge of output A, which comes in counter state 1, and then sample in states whose expected levels are known. The chopper result depends on the carrier phase, so it is checked against a narrow band, not an exact count.

// File: rtl/pwm_pkg.sv
// Package: shared types for the PWM generator.
// Assumes: codes here match the register field encodings in the brief.
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_HOLD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef struct packed {
        logic zero;
        logic period;
        logic ca_up;
        logic ca_dn;
        logic cb_up;
        logic cb_dn;
    } pwm_events_t;

    localparam int ACT_W = 12;

endpackage

// File: rtl/pwm_timebase.sv
// Module: time-base counter with shadowed period/compare values.
// Produces the per-state event flags used by the action stage.
// Assumes: shadow values are stable registers; active copies load at count zero.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] prd_sh,
    input  logic [CNT_W-1:0] cmpa_sh,
    input  logic [CNT_W-1:0] cmpb_sh,
    output pwm_events_t      ev
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] cmpa_act;
    logic [CNT_W-1:0] cmpb_act;
    logic             dir_up;
    logic             at_zero;

    assign at_zero = (cnt == '0);

    // Copy the shadow values into the active set at count zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_act  <= '0;
            cmpa_act <= '0;
            cmpb_act <= '0;
        end else if (at_zero) begin
            prd_act  <= prd_sh;
            cmpa_act <= cmpa_sh;
            cmpb_act <= cmpb_sh;
        end
    end

    // Step the counter and its direction according to the count mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else begin
            unique case (mode)
                MODE_UP: begin
                    dir_up <= 1'b1;
                    cnt    <= (cnt >= prd_act) ? '0 : cnt + 1'b1;
                end
                MODE_DOWN: begin
                    dir_up <= 1'b0;
                    cnt    <= (at_zero || cnt > prd_act) ? prd_act : cnt - 1'b1;
                end
                MODE_UPDOWN: begin
                    if (dir_up) begin
                        if (cnt >= prd_act) begin
                            dir_up <= 1'b0;
                            cnt    <= (prd_act == '0) ? '0 : cnt - 1'b1;
                        end else begin
                            cnt    <= cnt + 1'b1;
                        end
                    end else begin
                        if (at_zero) begin
                            dir_up <= 1'b1;
                            cnt    <= (prd_act == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt    <= cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    cnt <= cnt;
                end
            endcase
        end
    end

    // Decode the events of the current counter state.
    always_comb begin
        ev.zero   = at_zero;
        ev.period = (cnt == prd_act);
        ev.ca_up  = (cnt == cmpa_act) &&  dir_up;
        ev.ca_dn  = (cnt == cmpa_act) && !dir_up;
        ev.cb_up  = (cnt == cmpb_act) &&  dir_up;
        ev.cb_dn  = (cnt == cmpb_act) && !dir_up;
    end

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |=> (prd_act == $past(prd_sh)) && (cmpa_act == $past(cmpa_sh))); // R9
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP) && (cnt == prd_act) |=> cnt == '0); // R2
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN) && at_zero |=> cnt == $past(prd_act)); // R6
    AST_UD_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDOWN) && dir_up && (cnt == prd_act) && (prd_act != '0) |=> !dir_up); // R4

endmodule

// File: rtl/pwm_action_qual.sv
// Module: action qualifier for one output.
// Resolves the events of a state by fixed priority and updates the output register.
// Assumes: cfg holds six 2-bit act_e fields in the brief's field order.
module pwm_action_qual
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_events_t      ev,
    input  logic [ACT_W-1:0] cfg,
    output logic             q
);

    act_e sel;

    // Pick the winning action; later lines carry higher priority.
    always_comb begin
        sel = ACT_NONE;
        if (ev.zero   && cfg[1:0]   != 2'd0) sel = act_e'(cfg[1:0]);
        if (ev.period && cfg[3:2]   != 2'd0) sel = act_e'(cfg[3:2]);
        if (ev.ca_up  && cfg[5:4]   != 2'd0) sel = act_e'(cfg[5:4]);
        if (ev.ca_dn  && cfg[7:6]   != 2'd0) sel = act_e'(cfg[7:6]);
        if (ev.cb_up  && cfg[9:8]   != 2'd0) sel = act_e'(cfg[9:8]);
        if (ev.cb_dn  && cfg[11:10] != 2'd0) sel = act_e'(cfg[11:10]);
    end

    // Apply the chosen action to the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (sel)
                ACT_SET: q <= 1'b1;
                ACT_CLR: q <= 1'b0;
                ACT_TGL: q <= ~q;
                default: q <= q;
            endcase
        end
    end

    AST_ZERO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev.zero && !ev.period && !ev.ca_up && !ev.ca_dn && !ev.cb_up && !ev.cb_dn
        && (cfg[1:0] == 2'd2) |=> q); // R7
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev.zero && !ev.period && !ev.ca_up && !ev.ca_dn && !ev.cb_up && !ev.cb_dn
        |=> $stable(q)); // R7

endmodule

// File: rtl/pwm_chopper.sv
// Module: carrier chopper for both outputs.
// The carrier toggles every div+1 clocks; enabled outputs are ANDed with it.
// Assumes: div is a static register value.
module pwm_chopper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             in_a,
    input  logic             in_b,
    output logic             out_a,
    output logic             out_b
);

    logic [DIV_W-1:0] div_cnt;
    logic             carrier;

    // Run the divider and toggle the carrier on each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
            carrier <= 1'b0;
        end else if (div_cnt >= div) begin
            div_cnt <= '0;
            carrier <= ~carrier;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Gate the outputs with the carrier when the chopper is enabled.
    always_comb begin
        out_a = en ? (in_a & carrier) : in_a;
        out_b = en ? (in_b & carrier) : in_b;
    end

    AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en && (div_cnt < div) |=> $stable(carrier)); // R10
    AST_CARRIER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && (div_cnt >= div) |=> carrier != $past(carrier)); // R10

endmodule

// File: rtl/pwm_trip.sv
// Module: trip-zone override.
// trip_in forces outputs combinationally; a latch keeps the force until release.
// Assumes: clr is a one-cycle pulse; zero marks a counter-zero state.
module pwm_trip (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_in,
    input  logic       zero,
    input  logic       one_shot,
    input  logic       clr,
    input  logic [1:0] frc_a,
    input  logic [1:0] frc_b,
    input  logic       in_a,
    input  logic       in_b,
    output logic       out_a,
    output logic       out_b
);

    logic latched;
    logic active;

    // Hold the trip until a zero release or a software clear, by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= 1'b0;
        end else if (trip_in) begin
            latched <= 1'b1;
        end else if (one_shot ? clr : zero) begin
            latched <= 1'b0;
        end
    end

    assign active = trip_in | latched;

    // Apply the per-output force code while the trip is active.
    always_comb begin
        out_a = in_a;
        out_b = in_b;
        if (active && frc_a == 2'd1) out_a = 1'b0;
        if (active && frc_a == 2'd2) out_a = 1'b1;
        if (active && frc_b == 2'd1) out_b = 1'b0;
        if (active && frc_b == 2'd2) out_b = 1'b1;
    end

    AST_TRIP_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
        trip_in && (frc_a == 2'd1) |-> !out_a); // R11
    AST_TRIP_HIGH_B: assert property (@(posedge clk) disable iff (!rst_n)
        trip_in && (frc_b == 2'd2) |-> out_b); // R11
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        one_shot && latched && !clr |=> latched); // R13
    AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !one_shot && latched && zero && !trip_in |=> !latched); // R12

endmodule

// File: rtl/pwm_chop_trip.sv
// Module: top of the PWM generator; owns the register file.
// Chain: time base -> two action qualifiers -> chopper -> trip override.
// Assumes: write-only register port, one write per clock, fields per the brief.
module pwm_chop_trip
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 3,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             trip_in,
    output logic             out_a,
    output logic             out_b
);

    localparam logic [AW-1:0] A_PRD  = AW'(0);
    localparam logic [AW-1:0] A_CMPA = AW'(1);
    localparam logic [AW-1:0] A_CMPB = AW'(2);
    localparam logic [AW-1:0] A_MODE = AW'(3);
    localparam logic [AW-1:0] A_ACTA = AW'(4);
    localparam logic [AW-1:0] A_ACTB = AW'(5);
    localparam logic [AW-1:0] A_CHOP = AW'(6);
    localparam logic [AW-1:0] A_TRIP = AW'(7);
    localparam int NOUT = 2;

    logic [CNT_W-1:0] prd_sh, cmpa_sh, cmpb_sh;
    cnt_mode_e        mode_r;
    logic [ACT_W-1:0] act_r [NOUT];
    logic             chop_en;
    logic [DIV_W-1:0] chop_div;
    logic             os_mode;
    logic [1:0]       frc_a, frc_b;
    logic             trip_clr;
    pwm_events_t      ev;
    logic [NOUT-1:0]  aq_out;
    logic             ch_a, ch_b;

    // Capture register writes; the trip clear bit is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_sh   <= '0;
            cmpa_sh  <= '0;
            cmpb_sh  <= '0;
            mode_r   <= MODE_UP;
            act_r[0] <= '0;
            act_r[1] <= '0;
            chop_en  <= 1'b0;
            chop_div <= '0;
            os_mode  <= 1'b0;
            frc_a    <= 2'd0;
            frc_b    <= 2'd0;
            trip_clr <= 1'b0;
        end else begin
            trip_clr <= 1'b0;
            if (wr_en) begin
                unique case (wr_addr)
                    A_PRD:   prd_sh   <= wr_data;
                    A_CMPA:  cmpa_sh  <= wr_data;
                    A_CMPB:  cmpb_sh  <= wr_data;
                    A_MODE:  mode_r   <= cnt_mode_e'(wr_data[1:0]);
                    A_ACTA:  act_r[0] <= wr_data[ACT_W-1:0];
                    A_ACTB:  act_r[1] <= wr_data[ACT_W-1:0];
                    A_CHOP: begin
                        chop_en  <= wr_data[0];
                        chop_div <= wr_data[DIV_W:1];
                    end
                    default: begin
                        os_mode  <= wr_data[0];
                        frc_a    <= wr_data[2:1];
                        frc_b    <= wr_data[4:3];
                        trip_clr <= wr_data[5];
                    end
                endcase
            end
        end
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_r),
        .prd_sh  (prd_sh),
        .cmpa_sh (cmpa_sh),
        .cmpb_sh (cmpb_sh),
        .ev      (ev)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_aq
        pwm_action_qual u_aq (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev),
            .cfg   (act_r[g]),
            .q     (aq_out[g])
        );
    end

    pwm_chopper #(.DIV_W(DIV_W)) u_chop (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (chop_en),
        .div   (chop_div),
        .in_a  (aq_out[0]),
        .in_b  (aq_out[1]),
        .out_a (ch_a),
        .out_b (ch_b)
    );

    pwm_trip u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_in  (trip_in),
        .zero     (ev.zero),
        .one_shot (os_mode),
        .clr      (trip_clr),
        .frc_a    (frc_a),
        .frc_b    (frc_b),
        .in_a     (ch_a),
        .in_b     (ch_b),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !aq_out[0] && !aq_out[1]); // R1

endmodule

// File: tb/tb_pwm_chop_trip.sv
// Bench: scoreboard. Driver tasks push expected ranges; measured values are
// pushed to a second queue; a monitor process pairs and compares them.
module tb_pwm_chop_trip;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trip_in = 1'b0;
    logic        out_a, out_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    string req_q[$];
    int    lo_q[$];
    int    hi_q[$];
    int    act_q[$];

    always #2.5 clk = ~clk;

    pwm_chop_trip dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trip_in(trip_in), .out_a(out_a), .out_b(out_b)
    );

    // Action word: fields zero, period, A up, A down, B up, B down (R7).
    function automatic logic [15:0] actw(int z, int p, int au, int ad, int bu, int bd);
        return 16'({bd[1:0], bu[1:0], ad[1:0], au[1:0], p[1:0], z[1:0]});
    endfunction

    task automatic expect_val(string r, int lo, int hi, int actual);
        req_q.push_back(r);
        lo_q.push_back(lo);
        hi_q.push_back(hi);
        act_q.push_back(actual);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(int n, output int ca, output int cb);
        ca = 0;
        cb = 0;
        repeat (n) begin
            @(negedge clk);
            if (out_a) ca++;
            if (out_b) cb++;
        end
    endtask

    task automatic settle();
        repeat (300) @(negedge clk);
    endtask

    // Monitor: pop expected/actual pairs and compare.
    always @(negedge clk) begin
        while (act_q.size() > 0 && req_q.size() > 0) begin
            string r;
            int lo, hi, a;
            r  = req_q.pop_front();
            lo = lo_q.pop_front();
            hi = hi_q.pop_front();
            a  = act_q.pop_front();
            checks++;
            if (a < lo || a > hi) begin
                fails++;
                $display("FAIL %s actual=%0d expected=%0d..%0d", r, a, lo, hi);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ca, cb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R1 out_a after reset", 0, 0, int'(out_a));
        expect_val("R1 out_b after reset", 0, 0, int'(out_b));

        // R2/R3: up mode, P=9, A duty 3, B duty 6.
        wr(3, 0); wr(0, 9); wr(1, 3); wr(2, 6);
        wr(4, actw(2, 0, 1, 0, 0, 0));
        wr(5, actw(2, 0, 0, 0, 1, 0));
        settle();
        measure(100, ca, cb);
        expect_val("R2 up single-edge A", 30, 30, ca);
        expect_val("R3 independent B", 60, 60, cb);

        // R6: down mode, set at period, clear on A down match.
        wr(3, 1); wr(4, actw(0, 2, 0, 1, 0, 0));
        settle();
        measure(100, ca, cb);
        expect_val("R6 down A", 60, 60, ca);

        // R7: toggle at zero on A, set at period on B (P=4).
        wr(3, 0); wr(0, 4);
        wr(4, actw(3, 0, 0, 0, 0, 0));
        wr(5, actw(0, 2, 0, 0, 0, 0));
        settle();
        measure(100, ca, cb);
        expect_val("R7 toggle A", 50, 50, ca);
        expect_val("R7 set B", 100, 100, cb);

        // R8: simultaneous events at state 0.
        wr(0, 9); wr(1, 0); wr(2, 0);
        wr(4, actw(2, 0, 1, 0, 0, 0));
        wr(5, actw(2, 0, 0, 0, 3, 0));
        settle();
        measure(100, ca, cb);
        expect_val("R8 compare A clear beats zero set", 0, 0, ca);
        expect_val("R8 compare B toggle beats zero set", 50, 50, cb);

        // R4: up-down symmetric, P=10, C=4.
        wr(3, 2); wr(0, 10); wr(1, 4); wr(2, 4);
        wr(4, actw(0, 0, 2, 1, 0, 0));
        wr(5, actw(0, 0, 0, 0, 1, 2));
        settle();
        measure(100, ca, cb);
        expect_val("R4 symmetric A", 60, 60, ca);
        expect_val("R4 symmetric B complement", 40, 40, cb);

        // R5: asymmetric, set on A up (2), clear on B down (8).
        wr(1, 2); wr(2, 8);
        wr(4, actw(0, 0, 2, 0, 0, 1));
        settle();
        measure(100, ca, cb);
        expect_val("R5 asymmetric A", 50, 50, ca);

        // R9: shadow compare, P=99, C=50, rewrite C=20 in state 1.
        wr(3, 0); wr(0, 99); wr(1, 50);
        wr(4, actw(2, 0, 1, 0, 0, 0));
        wr(5, actw(2, 0, 0, 0, 1, 0)); wr(2, 50);
        settle();
        do @(negedge clk); while (out_a);
        do @(negedge clk); while (!out_a);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd20;
        @(negedge clk);
        wr_en = 1'b0;
        measure(98, ca, cb);
        expect_val("R9 current cycle keeps old compare", 48, 48, ca);
        measure(100, ca, cb);
        expect_val("R9 next cycle uses new compare", 20, 20, ca);

        // R2 baseline then R10 chopper (carrier period 4).
        wr(1, 50);
        settle();
        measure(200, ca, cb);
        expect_val("R2 half duty before chopping", 100, 100, ca);
        wr(6, 3);
        settle();
        measure(200, ca, cb);
        expect_val("R10 chopped A", 46, 54, ca);
        expect_val("R10 chopped B", 46, 54, cb);
        wr(6, 0);

        // R11/R12: cycle-by-cycle, A forced low, B forced high. P=9, C=5.
        wr(0, 9); wr(1, 5); wr(2, 5); wr(7, 18);
        settle();
        do @(negedge clk); while (out_a);
        do @(negedge clk); while (!out_a);
        trip_in = 1'b1;
        #1;
        expect_val("R11 A forced low same cycle", 0, 0, int'(out_a));
        expect_val("R11 B forced high same cycle", 1, 1, int'(out_b));
        @(negedge clk);
        trip_in = 1'b0;
        @(negedge clk);
        expect_val("R12 A held before zero", 0, 0, int'(out_a));
        expect_val("R12 B held before zero", 1, 1, int'(out_b));
        repeat (10) @(negedge clk);
        measure(100, ca, cb);
        expect_val("R12 A released after zero", 50, 50, ca);
        expect_val("R12 B released after zero", 50, 50, cb);

        // R13: one-shot holds across zeros until cleared.
        wr(7, 19);
        @(negedge clk); trip_in = 1'b1;
        @(negedge clk); trip_in = 1'b0;
        repeat (30) @(negedge clk);
        measure(40, ca, cb);
        expect_val("R13 A held", 0, 0, ca);
        expect_val("R13 B held", 40, 40, cb);
        wr(7, 51);
        repeat (20) @(negedge clk);
        measure(100, ca, cb);
        expect_val("R13 A after clear", 50, 50, ca);
        expect_val("R13 B after clear", 50, 50, cb);

        // R11: code 0 leaves B running while A is forced.
        wr(7, 3);
        @(negedge clk); trip_in = 1'b1;
        @(negedge clk); trip_in = 1'b0;
        repeat (30) @(negedge clk);
        measure(100, ca, cb);
        expect_val("R11 A forced", 0, 0, ca);
        expect_val("R11 B no override", 50, 50, cb);
        wr(7, 35);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule